// File: doc/BRIEF.md
# Permission-Checking Translation Cache

This block is a small fully associative cache of address translations. A requester presents a 48-bit virtual address together with an access kind (read, write or execute). One clock later the block answers with one of three outcomes. A hit returns the 40-bit physical address. A protection fault means the page is cached but the access kind is not permitted. A miss means no cached translation exists, and the requester must then walk its page tables elsewhere. The low 12 address bits are the offset within a 4 KB page. They pass through unchanged, and the cached frame number is placed directly above them.

Each of the eight entries holds a virtual page number, a frame number, a valid flag, separate read, write and execute permissions, and a modified (dirty) flag and a recently-used (reference) flag. Once a miss has been resolved, the requester installs the translation through the fill port. The fill goes to the lowest-numbered free entry. When no entry is free, it overwrites the entry named by a rotating pointer. A flush input empties the whole cache when the address space changes.

A three-state occupancy machine controls replacement. Its states are `TBL_EMPTY`, `TBL_PARTIAL` and `TBL_FULL`. A fill moves `TBL_EMPTY` to `TBL_PARTIAL`. A fill that takes the last free entry moves `TBL_PARTIAL` to `TBL_FULL`. `TBL_FULL` holds on further fills, which use the rotating pointer. A flush returns any state to `TBL_EMPTY`.

Top module: `tlb_perm`

## Requirements
- R1: After reset every entry is invalid, the replacement pointer is at entry 0, and all response outputs are 0.
- R2: A lookup request in cycle N gives `rsp_valid_o` high in cycle N+1 with exactly one of hit, fault or miss set. With no request, all four response flags are 0.
- R3: On a hit, `rsp_paddr_o` equals the entry's frame number concatenated with address bits [11:0]. On a fault, a miss or an idle cycle it is 0.
- R4: A lookup whose page number matches no valid entry reports a miss.
- R5: Access encoding is 0 read, 1 write, 2 execute and 3 reserved. An access whose permission bit is clear in the matching entry is refused with a fault. Code 3 is always refused.
- R6: On a match, `rsp_ref_o` shows the entry's reference flag as it was before the access. A permitted hit sets the flag. A fill clears it. A fault leaves it unchanged.
- R7: On a match, `rsp_dirty_o` shows the entry's modified flag as it was before the access. A permitted write sets it. A fill clears it.
- R8: While any entry is free, a fill takes a free entry and displaces no valid translation.
- R9: With all entries valid, fills overwrite entries in rotating order. The order starts at entry 0 after reset or flush and advances by one per overwrite, wrapping after entry 7.
- R10: A flush invalidates every entry. A lookup in the same cycle as a flush reports a miss.
- R11: A fill in the same cycle as a flush is discarded, and the cache is left empty.
- R12: A lookup is judged against the contents before any fill in the same cycle. A fill overrides a flag update to the entry it overwrites.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 48 | Virtual address to translate |
| lk_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | 36 | Virtual page number to install |
| fill_pfn_i | input | 28 | Frame number to install |
| fill_rd_i | input | 1 | Read permission of the new entry |
| fill_wr_i | input | 1 | Write permission of the new entry |
| fill_ex_i | input | 1 | Execute permission of the new entry |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Permitted hit |
| rsp_fault_o | output | 1 | Matched but access refused |
| rsp_miss_o | output | 1 | No matching translation |
| rsp_paddr_o | output | 40 | Physical address on a hit |
| rsp_dirty_o | output | 1 | Prior modified flag of the matched entry |
| rsp_ref_o | output | 1 | Prior reference flag of the matched entry |

## Verification
Two pairs of functions can land in the same cycle. Flush with fill is the first. The bench drives both together and then looks up the filled page, which must miss. A later round of fills must start again from free entries. Lookup with fill is the second. The bench checks that a page being installed misses in that same cycle. It also checks that when a full cache overwrites an entry that is being hit, the new translation keeps clear flags. Random traffic over a small page pool mixes all four inputs, so these collisions occur often, and each response is compared with a bench model of the cache.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        TBL_EMPTY   = 2'd0,
        TBL_PARTIAL = 2'd1,
        TBL_FULL    = 2'd2
    } tbl_state_e;
endpackage

// File: rtl/tlbp_match.sv
module tlbp_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 36,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tag_i,
    input  logic [VPN_W-1:0]              key_i,
    output logic                          any_o,
    output logic [IDX_W-1:0]              idx_o
);
    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_i[g] && (tag_i[g] == key_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |hit_vec;
endmodule

// File: rtl/tlbp_victim.sv
module tlbp_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [IDX_W-1:0]   rr_i,
    input  logic               full_i,
    output logic [IDX_W-1:0]   idx_o
);
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) free_idx = IDX_W'(i);
        end
    end

    assign idx_o = full_i ? rr_i : free_idx;
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlbp_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 36,
    parameter int PFN_W   = 28,
    parameter int OFS_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int VA_W   = VPN_W + OFS_W,
    localparam int PA_W   = PFN_W + OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             lk_valid_i,
    input  logic [VA_W-1:0]  lk_vaddr_i,
    input  logic [1:0]       lk_acc_i,
    input  logic             fill_valid_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [PFN_W-1:0] fill_pfn_i,
    input  logic             fill_rd_i,
    input  logic             fill_wr_i,
    input  logic             fill_ex_i,
    output logic             rsp_valid_o,
    output logic             rsp_hit_o,
    output logic             rsp_fault_o,
    output logic             rsp_miss_o,
    output logic [PA_W-1:0]  rsp_paddr_o,
    output logic             rsp_dirty_o,
    output logic             rsp_ref_o
);
    // table storage
    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
    logic [ENTRIES-1:0]            rd_q, wr_q, ex_q, dirty_q, ref_q;
    logic [IDX_W-1:0]              rr_q;
    tbl_state_e                    state_q, state_d;

    // lookup path
    logic             m_any;
    logic [IDX_W-1:0] m_idx;
    logic             allow;
    logic             take_hit, take_fault;

    tlbp_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
        .valid_i (valid_q),
        .tag_i   (vpn_q),
        .key_i   (lk_vaddr_i[VA_W-1:OFS_W]),
        .any_o   (m_any),
        .idx_o   (m_idx)
    );

    always_comb begin
        unique case (lk_acc_i)
            ACC_READ:  allow = rd_q[m_idx];
            ACC_WRITE: allow = wr_q[m_idx];
            ACC_EXEC:  allow = ex_q[m_idx];
            default:   allow = 1'b0;
        endcase
    end

    assign take_hit   = lk_valid_i && !flush_i && m_any && allow;
    assign take_fault = lk_valid_i && !flush_i && m_any && !allow;

    // fill path
    logic [IDX_W-1:0]   vic_idx;
    logic [ENTRIES-1:0] vic_oh;
    logic               fill_go, fill_last;

    tlbp_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid_i (valid_q),
        .rr_i    (rr_q),
        .full_i  (state_q == TBL_FULL),
        .idx_o   (vic_idx)
    );

    assign vic_oh    = ENTRIES'(1) << vic_idx;
    assign fill_go   = fill_valid_i && !flush_i;
    assign fill_last = &(valid_q | vic_oh);

    // occupancy machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TBL_EMPTY:   if (fill_go) state_d = fill_last ? TBL_FULL : TBL_PARTIAL;
            TBL_PARTIAL: if (fill_go && fill_last) state_d = TBL_FULL;
            TBL_FULL:    state_d = TBL_FULL;
            default:     state_d = TBL_EMPTY;
        endcase
        if (flush_i) state_d = TBL_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TBL_EMPTY;
        else        state_q <= state_d;
    end

    // table update: flag update first, a fill to the same slot overrides it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            ref_q   <= '0;
            rr_q    <= '0;
        end else if (flush_i) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else begin
            if (take_hit) begin
                ref_q[m_idx] <= 1'b1;
                if (lk_acc_i == ACC_WRITE) dirty_q[m_idx] <= 1'b1;
            end
            if (fill_go) begin
                valid_q[vic_idx] <= 1'b1;
                dirty_q[vic_idx] <= 1'b0;
                ref_q[vic_idx]   <= 1'b0;
                if (state_q == TBL_FULL)
                    rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_go) begin
            vpn_q[vic_idx] <= fill_vpn_i;
            pfn_q[vic_idx] <= fill_pfn_i;
            rd_q[vic_idx]  <= fill_rd_i;
            wr_q[vic_idx]  <= fill_wr_i;
            ex_q[vic_idx]  <= fill_ex_i;
        end
    end

    // registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_hit_o   <= 1'b0;
            rsp_fault_o <= 1'b0;
            rsp_miss_o  <= 1'b0;
            rsp_paddr_o <= '0;
            rsp_dirty_o <= 1'b0;
            rsp_ref_o   <= 1'b0;
        end else begin
            rsp_valid_o <= lk_valid_i;
            rsp_hit_o   <= take_hit;
            rsp_fault_o <= take_fault;
            rsp_miss_o  <= lk_valid_i && (flush_i || !m_any);
            rsp_paddr_o <= take_hit ? {pfn_q[m_idx], lk_vaddr_i[OFS_W-1:0]} : '0;
            rsp_dirty_o <= (take_hit || take_fault) ? dirty_q[m_idx] : 1'b0;
            rsp_ref_o   <= (take_hit || take_fault) ? ref_q[m_idx] : 1'b0;
        end
    end
endmodule

// File: rtl/tlbp_chk.sv
module tlbp_chk
    import tlbp_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VA_W    = 48,
    parameter int PA_W    = 40,
    parameter int OFS_W   = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_i,
    input logic               lk_valid_i,
    input logic [VA_W-1:0]    lk_vaddr_i,
    input logic [1:0]         lk_acc_i,
    input logic               fill_valid_i,
    input logic               rsp_valid_o,
    input logic               rsp_hit_o,
    input logic               rsp_fault_o,
    input logic               rsp_miss_o,
    input logic [PA_W-1:0]    rsp_paddr_o,
    input logic [ENTRIES-1:0] valid_q,
    input logic [1:0]         state_i
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $countones({rsp_hit_o, rsp_fault_o, rsp_miss_o}) == 1); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_o |-> !(rsp_hit_o || rsp_fault_o || rsp_miss_o)); // R2
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i |=> rsp_valid_o); // R2
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i |=> (!rsp_hit_o || rsp_paddr_o[OFS_W-1:0] == $past(lk_vaddr_i[OFS_W-1:0]))); // R3
    AST_NONHIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit_o |-> rsp_paddr_o == '0); // R3
    AST_RSVD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid_i && lk_acc_i == 2'd3) |=> !rsp_hit_o); // R5
    AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid_i && !flush_i && !(&valid_q)) |=>
            $countones(valid_q) == $countones($past(valid_q)) + 1); // R8
    AST_FULL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_q) == (state_i == TBL_FULL)); // R9
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_q == '0 && state_i == TBL_EMPTY)); // R11
    AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && lk_valid_i) |=> rsp_miss_o); // R10
endmodule

bind tlb_perm tlbp_chk #(
    .ENTRIES (ENTRIES),
    .VA_W    (VA_W),
    .PA_W    (PA_W),
    .OFS_W   (OFS_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .lk_valid_i   (lk_valid_i),
    .lk_vaddr_i   (lk_vaddr_i),
    .lk_acc_i     (lk_acc_i),
    .fill_valid_i (fill_valid_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_hit_o    (rsp_hit_o),
    .rsp_fault_o  (rsp_fault_o),
    .rsp_miss_o   (rsp_miss_o),
    .rsp_paddr_o  (rsp_paddr_o),
    .valid_q      (valid_q),
    .state_i      (state_q)
);

// File: tb/tlb_perm_bench.sv
module tlb_perm_bench;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        lk_valid_i = 1'b0;
    logic [47:0] lk_vaddr_i = '0;
    logic [1:0]  lk_acc_i = '0;
    logic        fill_valid_i = 1'b0;
    logic [35:0] fill_vpn_i = '0;
    logic [27:0] fill_pfn_i = '0;
    logic        fill_rd_i = 1'b0, fill_wr_i = 1'b0, fill_ex_i = 1'b0;
    logic        rsp_valid_o, rsp_hit_o, rsp_fault_o, rsp_miss_o;
    logic [39:0] rsp_paddr_o;
    logic        rsp_dirty_o, rsp_ref_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    tlb_perm u_tlb_perm (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .lk_valid_i(lk_valid_i), .lk_vaddr_i(lk_vaddr_i), .lk_acc_i(lk_acc_i),
        .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_pfn_i(fill_pfn_i),
        .fill_rd_i(fill_rd_i), .fill_wr_i(fill_wr_i), .fill_ex_i(fill_ex_i),
        .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_fault_o(rsp_fault_o),
        .rsp_miss_o(rsp_miss_o), .rsp_paddr_o(rsp_paddr_o),
        .rsp_dirty_o(rsp_dirty_o), .rsp_ref_o(rsp_ref_o)
    );

    // bench model of the cache
    bit        m_v [N];
    bit [35:0] m_vpn [N];
    bit [27:0] m_pfn [N];
    bit        m_r [N], m_w [N], m_x [N], m_d [N], m_rf [N];
    int        m_rr = 0;

    function automatic bit perm_ok(input bit [1:0] acc, input int i);
        case (acc)
            2'd0: return m_r[i];
            2'd1: return m_w[i];
            2'd2: return m_x[i];
            default: return 1'b0;
        endcase
    endfunction

    function automatic int find(input bit [35:0] vpn);
        for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
        return -1;
    endfunction

    function automatic bit all_valid();
        for (int i = 0; i < N; i++) if (!m_v[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus with its predicted response
    task automatic cyc(input bit lv, input bit [47:0] va, input bit [1:0] acc,
                       input bit fv, input bit [35:0] fvpn, input bit [27:0] fpfn,
                       input bit fr, input bit fw, input bit fx,
                       input bit fl, input string tag);
        int idx;
        bit ok;
        logic [63:0] exp;
        lk_valid_i = lv; lk_vaddr_i = va; lk_acc_i = acc;
        fill_valid_i = fv; fill_vpn_i = fvpn; fill_pfn_i = fpfn;
        fill_rd_i = fr; fill_wr_i = fw; fill_ex_i = fx;
        flush_i = fl;
        idx = (lv && !fl) ? find(va[47:12]) : -1;
        ok  = (idx >= 0) ? perm_ok(acc, idx) : 1'b0;
        exp = '0;
        if (lv) begin
            exp[45] = 1'b1;
            if (idx < 0) exp[42] = 1'b1;
            else begin
                exp[44] = ok; exp[43] = !ok;
                exp[41] = m_d[idx]; exp[40] = m_rf[idx];
                if (ok) exp[39:0] = {m_pfn[idx], va[11:0]};
            end
        end
        if (fl) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
            m_rr = 0;
        end else begin
            if (idx >= 0 && ok) begin
                m_rf[idx] = 1'b1;
                if (acc == 2'd1) m_d[idx] = 1'b1;
            end
            if (fv) begin
                int v;
                if (all_valid()) begin
                    v = m_rr; m_rr = (m_rr + 1) % N;
                end else begin
                    v = 0;
                    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) v = i;
                end
                m_v[v] = 1; m_vpn[v] = fvpn; m_pfn[v] = fpfn;
                m_r[v] = fr; m_w[v] = fw; m_x[v] = fx; m_d[v] = 0; m_rf[v] = 0;
            end
        end
        @(negedge clk);
        chk(tag, {18'd0, rsp_valid_o, rsp_hit_o, rsp_fault_o, rsp_miss_o,
                  rsp_dirty_o, rsp_ref_o, rsp_paddr_o}, exp);
    endtask

    task automatic look(input bit [35:0] vpn, input bit [11:0] ofs, input bit [1:0] acc, input string tag);
        cyc(1, {vpn, ofs}, acc, 0, '0, '0, 0, 0, 0, 0, tag);
    endtask

    task automatic fill(input bit [35:0] vpn, input bit [27:0] pfn, input bit r, input bit w, input bit x, input string tag);
        cyc(0, '0, 0, 1, vpn, pfn, r, w, x, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", {rsp_valid_o, rsp_hit_o, rsp_fault_o, rsp_miss_o, rsp_dirty_o, rsp_ref_o, rsp_paddr_o}, '0);
        look(36'hA_0000_0001, 12'h123, 0, "R1");
        // R12: lookup in the cycle of its own fill misses
        cyc(1, {36'hA_0000_0001, 12'h010}, 0, 1, 36'hA_0000_0001, 28'hABC_DEF0, 1, 0, 0, 0, "R12");
        look(36'hA_0000_0001, 12'hFFF, 0, "R3");
        look(36'hA_0000_0001, 12'h001, 0, "R6");
        look(36'hA_0000_0001, 12'h002, 1, "R5");
        look(36'hA_0000_0001, 12'h003, 2, "R5");
        look(36'hA_0000_0001, 12'h004, 3, "R5");
        fill(36'hB_0000_0002, 28'h111_2222, 1, 1, 0, "R8");
        look(36'hB_0000_0002, 12'h800, 1, "R7");
        look(36'hB_0000_0002, 12'h801, 0, "R7");
        look(36'hC_0000_0003, 12'h000, 0, "R4");
        cyc(1, {36'hB_0000_0002, 12'h0}, 0, 0, '0, '0, 0, 0, 0, 1, "R10");
        look(36'hA_0000_0001, 12'h0, 0, "R10");
        // R8/R9: fill to capacity, then rotate
        for (int i = 0; i < N; i++) fill(36'h1_0000_0000 + 36'(i), 28'(i + 100), 1, 1, 1, "R8");
        for (int i = 0; i < N; i++) look(36'h1_0000_0000 + 36'(i), 12'h5A5, 0, "R8");
        fill(36'h2_0000_0000, 28'h777, 1, 1, 1, "R9");
        look(36'h1_0000_0000, 12'h0, 0, "R9");
        look(36'h1_0000_0001, 12'h0, 0, "R9");
        // R12: hit on entry 1 while it is overwritten; new entry has clear flags
        cyc(1, {36'h1_0000_0001, 12'h0}, 1, 1, 36'h2_0000_0001, 28'h888, 1, 1, 1, 0, "R12");
        look(36'h2_0000_0001, 12'h0, 0, "R12");
        look(36'h1_0000_0001, 12'h0, 0, "R9");
        // R11: flush beats fill
        cyc(0, '0, 0, 1, 36'h3_0000_0000, 28'h999, 1, 1, 1, 1, "R11");
        look(36'h3_0000_0000, 12'h0, 0, "R11");
        look(36'h2_0000_0000, 12'h0, 0, "R11");
        fill(36'h3_0000_0001, 28'h5, 1, 0, 0, "R11");
        look(36'h3_0000_0001, 12'h0, 0, "R11");
        // random traffic over a small page pool
        for (int n = 0; n < 4000; n++) begin
            bit [35:0] lvpn, fvpn;
            bit fv;
            lvpn = 36'h5_0000_0000 + 36'($urandom % 14);
            fvpn = 36'h5_0000_0000 + 36'($urandom % 14);
            fv = ($urandom % 3 == 0) && (find(fvpn) < 0);
            cyc($urandom % 2, {lvpn, 12'($urandom)}, 2'($urandom), fv, fvpn, 28'($urandom),
                $urandom % 2, $urandom % 2, $urandom % 2, ($urandom % 50 == 0), "R2");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule